// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block sits between the interrupt request pins of a processor core and its control sequencer. Three active-low request lines carry a binary priority code. The block synchronizes them, filters glitches and turns the code into a pending level from 0 to 7. It compares that level with the current 3-bit interrupt mask. When it accepts a request, it pulses `int_take` toward the core, reports the level it accepted, raises the mask to that level and pushes the old mask onto a small nesting stack. When the handler finishes, a one-cycle `svc_done` pulse pops the stack and brings the saved mask back.

Level 7 is non-maskable. It is accepted even when the mask already holds 7. It is armed by the pending level leaving 7, so a line held at 7 fires only once. The block also decodes bus cycles: it drives `iack_strobe` while the cycle-type code reads as an interrupt-acknowledge cycle and the address strobe is asserted (low).

Control is a three-state machine:
- ST_WATCH evaluates requests. It goes to ST_RESTORE on a restore with a non-empty stack. Otherwise it goes to ST_ACCEPT when a request is accepted. Otherwise it stays in ST_WATCH.
- ST_ACCEPT lasts one cycle, drives `int_take` and always returns to ST_WATCH.
- ST_RESTORE lasts one cycle, so the popped mask is in place before the next comparison, and always returns to ST_WATCH.

Top module: `irq_level_arbiter`

## Requirements
- R1: The pending level is the bitwise inverse of `irq_n`. `irq_n` = 3'b111 means no request (level 0), 3'b110 means level 1, and 3'b000 means level 7.
- R2: A change on `irq_n` must hold for two synchronized samples before it is recognized. When a change is applied before clock edge 1 and is accepted, `int_take` is first high after edge 5. A value present for only one cycle is never recognized.
- R3: A request of level 1 to 6 is accepted only when its level is above the current mask. On acceptance, `int_take` is high for exactly one cycle and `taken_level` shows the accepted level.
- R4: On acceptance, `mask_level` becomes the accepted level in the same edge that raises `int_take`.
- R5: A request whose level is not above the mask stays pending. It is accepted once a restore lowers the mask below it.
- R6: Level 7 is accepted whatever the mask, including when the mask is 7.
- R7: Level 7 is accepted only after the pending level has been something other than 7. A level held at 7 is never accepted twice, even after a restore lowers the mask.
- R8: A `svc_done` pulse in ST_WATCH with a non-empty stack loads the most recently saved mask into `mask_level`. Saved masks come back in last-in, first-out order.
- R9: A `svc_done` pulse with an empty stack leaves `mask_level` unchanged.
- R10: While the stack holds NEST_DEPTH saved masks, no request of any level is accepted. The request stays pending until a restore frees an entry.
- R11: `iack_strobe` is high exactly when `cycle_code` = 3'b111 and `addr_strobe_n` = 0. It is low for any other code, and it is low whenever the strobe is high.
- R12: After reset, `mask_level` = RESET_MASK (default 0), `int_take` = 0, `taken_level` = 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 3 | Active-low interrupt priority code |
| svc_done | input | 1 | End-of-service pulse; restores the saved mask |
| cycle_code | input | 3 | Bus cycle-type code |
| addr_strobe_n | input | 1 | Address strobe, active low |
| int_take | output | 1 | One-cycle acceptance pulse toward the core |
| taken_level | output | 3 | Level of the most recently accepted request |
| mask_level | output | 3 | Current interrupt mask |
| iack_strobe | output | 1 | Interrupt-acknowledge cycle decode |

## Verification
A request change reaches `int_take` after five clock edges: three synchronizer stages, one stability register and the state transition. Mask restores take effect one edge after the `svc_done` pulse, and a pending request that the restore unblocks fires two edges after that. The acknowledge decode is combinational and is sampled 1 ns after its inputs change. The bench drives inputs on falling edges and samples on falling edges. The latency check inspects each of the five edges individually. Every table vector waits a fixed window well beyond these latencies and counts acceptance pulses with a posedge monitor, so the check does not depend on exact arrival.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_NONE = 3'd0;
    localparam logic [LVL_W-1:0] LVL_NMI  = 3'd7;
    localparam logic [2:0]       CODE_IACK = 3'b111;

    typedef enum logic [1:0] {
        ST_WATCH   = 2'd0,
        ST_ACCEPT  = 2'd1,
        ST_RESTORE = 2'd2
    } arb_state_t;

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_n_i,
    output logic [W-1:0] level_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '1;
            sync_q  <= '1;
            prev_q  <= '1;
            level_q <= '0;
        end else begin
            meta_q <= req_n_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (sync_q == prev_q) begin
                level_q <= ~sync_q;
            end
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BITS  = DEPTH * W;

    logic [BITS-1:0]      ent_q;
    logic [BITS+W-1:0]    push_ext;
    logic [BITS+W-1:0]    pop_ext;
    logic [CNT_W-1:0]     cnt_q;

    assign push_ext = {ent_q, din};
    assign pop_ext  = {{W{1'b0}}, ent_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else if (push && !full) begin
            ent_q <= push_ext[BITS-1:0];
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            ent_q <= pop_ext[BITS+W-1:W];
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign top   = ent_q[W-1:0];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/iack_decode.sv
module iack_decode
    import irq_arb_pkg::*;
(
    input  logic [2:0] cycle_code,
    input  logic       addr_strobe_n,
    output logic       strobe
);

    always_comb begin
        strobe = !addr_strobe_n && (cycle_code == CODE_IACK);
    end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int               NEST_DEPTH = 2,
    parameter logic [LVL_W-1:0] RESET_MASK = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_n,
    input  logic             svc_done,
    input  logic [2:0]       cycle_code,
    input  logic             addr_strobe_n,
    output logic             int_take,
    output logic [LVL_W-1:0] taken_level,
    output logic [LVL_W-1:0] mask_level,
    output logic             iack_strobe
);

    arb_state_t       state_q, state_d;
    logic [LVL_W-1:0] pend_lvl;
    logic [LVL_W-1:0] mask_q;
    logic [LVL_W-1:0] taken_q;
    logic             nmi_armed_q;
    logic [LVL_W-1:0] stk_top;
    logic             stk_empty;
    logic             stk_full;
    logic             nmi_req;
    logic             std_req;
    logic             do_push;
    logic             do_pop;

    irq_level_sync #(.W(LVL_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (irq_n),
        .level_o (pend_lvl)
    );

    mask_stack #(.DEPTH(NEST_DEPTH), .W(LVL_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .din   (mask_q),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    iack_decode u_iack (
        .cycle_code    (cycle_code),
        .addr_strobe_n (addr_strobe_n),
        .strobe        (iack_strobe)
    );

    // request qualification
    always_comb begin
        nmi_req = (pend_lvl == LVL_NMI) && nmi_armed_q;
        std_req = (pend_lvl != LVL_NONE) && (pend_lvl != LVL_NMI) && (pend_lvl > mask_q);
        do_pop  = (state_q == ST_WATCH) && svc_done && !stk_empty;
        do_push = (state_q == ST_WATCH) && !do_pop && !stk_full && (nmi_req || std_req);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: begin
                if (do_pop) begin
                    state_d = ST_RESTORE;
                end else if (do_push) begin
                    state_d = ST_ACCEPT;
                end else begin
                    state_d = ST_WATCH;
                end
            end
            ST_ACCEPT:  state_d = ST_WATCH;
            ST_RESTORE: state_d = ST_WATCH;
            default:    state_d = ST_WATCH;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_WATCH;
            mask_q      <= RESET_MASK;
            taken_q     <= LVL_NONE;
            nmi_armed_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (do_push) begin
                mask_q  <= pend_lvl;
                taken_q <= pend_lvl;
            end else if (do_pop) begin
                mask_q <= stk_top;
            end
            if (pend_lvl != LVL_NMI) begin
                nmi_armed_q <= 1'b1;
            end else if (do_push && nmi_req) begin
                nmi_armed_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        int_take    = (state_q == ST_ACCEPT);
        taken_level = taken_q;
        mask_level  = mask_q;
    end

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       int_take,
    input logic [2:0] taken_level,
    input logic [2:0] mask_level,
    input logic       svc_done,
    input logic       stk_full,
    input logic       iack_strobe,
    input logic       addr_strobe_n
);

    // R3: acceptance is a single-cycle pulse
    a_r3_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> !int_take);

    // R3 / R6: accepted level exceeds the prior mask unless non-maskable
    a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> ((taken_level > $past(mask_level)) || (taken_level == 3'd7)));

    // R4: mask equals the accepted level while acknowledging
    a_r4_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (mask_level == taken_level));

    // R5 / R8: the mask only drops after a restore pulse
    a_r5_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(svc_done) |-> (mask_level >= $past(mask_level)));

    // R10: a full stack blocks acceptance
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !int_take);

    // R11: acknowledge decode needs the strobe asserted
    a_r11_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        iack_strobe |-> !addr_strobe_n);

endmodule

bind irq_level_arbiter irq_level_arbiter_chk u_chk (.*);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] irq_n = 3'b111;
    logic       svc_done = 1'b0;
    logic [2:0] cycle_code = 3'b000;
    logic       addr_strobe_n = 1'b1;
    logic       int_take;
    logic [2:0] taken_level;
    logic [2:0] mask_level;
    logic       iack_strobe;

    int compared = 0;
    int mismatched = 0;
    int pulse_cnt = 0;
    logic [2:0] last_lvl = 3'd0;

    always #5 clk = ~clk;

    irq_level_arbiter u_irq_level_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_n         (irq_n),
        .svc_done      (svc_done),
        .cycle_code    (cycle_code),
        .addr_strobe_n (addr_strobe_n),
        .int_take      (int_take),
        .taken_level   (taken_level),
        .mask_level    (mask_level),
        .iack_strobe   (iack_strobe)
    );

    always @(posedge clk) begin
        if (int_take) begin
            pulse_cnt <= pulse_cnt + 1;
            last_lvl  <= taken_level;
        end
    end

    // vector: [11:9] irq_n, [8] restore, [7:6] pulses, [5:3] level, [2:0] mask
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        {3'b100, 1'b0, 2'd1, 3'd3, 3'd3},
        {3'b101, 1'b0, 2'd0, 3'd0, 3'd3},
        {3'b010, 1'b0, 2'd1, 3'd5, 3'd5},
        {3'b001, 1'b0, 2'd0, 3'd0, 3'd5},
        {3'b001, 1'b1, 2'd1, 3'd6, 3'd6},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd3},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd0},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd0},
        {3'b001, 1'b0, 2'd1, 3'd6, 3'd6},
        {3'b000, 1'b0, 2'd1, 3'd7, 3'd7},
        {3'b000, 1'b1, 2'd0, 3'd0, 3'd6},
        {3'b111, 1'b0, 2'd0, 3'd0, 3'd6},
        {3'b000, 1'b0, 2'd1, 3'd7, 3'd7},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd6},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd0},
        {3'b000, 1'b0, 2'd1, 3'd7, 3'd7},
        {3'b111, 1'b0, 2'd0, 3'd0, 3'd7},
        {3'b000, 1'b0, 2'd1, 3'd7, 3'd7},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd7},
        {3'b111, 1'b1, 2'd0, 3'd0, 3'd0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R1 R3 R4";
            1:       return "R5";
            2:       return "R3 R4";
            3:       return "R10";
            4:       return "R5 R8 R10";
            5, 6:    return "R8";
            7:       return "R9";
            8, 9:    return "R3 R6";
            10:      return "R7";
            11:      return "R1";
            12:      return "R7";
            13, 14:  return "R8";
            15, 16:  return "R6";
            17:      return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_restore();
        @(negedge clk);
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        // reset state (R12)
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 mask", mask_level, 0);
        chk("R12 int_take", int_take, 0);
        chk("R12 taken_level", taken_level, 0);

        // acknowledge decode (R11)
        cycle_code = 3'b111; addr_strobe_n = 1'b0; #1;
        chk("R11 code 111 strobe low", iack_strobe, 1);
        addr_strobe_n = 1'b1; #1;
        chk("R11 strobe high", iack_strobe, 0);
        cycle_code = 3'b110; addr_strobe_n = 1'b0; #1;
        chk("R11 code 110", iack_strobe, 0);
        cycle_code = 3'b000; addr_strobe_n = 1'b1;

        // one-cycle glitch is not recognized (R2)
        @(negedge clk);
        base = pulse_cnt;
        irq_n = 3'b100;
        @(negedge clk);
        irq_n = 3'b111;
        cycles(10);
        chk("R2 glitch pulses", pulse_cnt - base, 0);
        chk("R2 glitch mask", mask_level, 0);

        // exact latency (R2, R1 level 1)
        irq_n = 3'b110;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R2 early edge", int_take, 0);
        end
        @(negedge clk);
        chk("R2 fifth edge take", int_take, 1);
        chk("R1 level one", taken_level, 1);
        @(negedge clk);
        chk("R3 single pulse", int_take, 0);
        irq_n = 3'b111;
        cycles(6);
        pulse_restore();
        cycles(4);
        chk("R8 restore to zero", mask_level, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            base = pulse_cnt;
            irq_n = v[11:9];
            cycles(10);
            if (v[8]) begin
                pulse_restore();
                cycles(8);
            end
            chk(vec_tag(i), pulse_cnt - base, int'(v[7:6]));
            if (v[7:6] != 2'd0) chk(vec_tag(i), last_lvl, int'(v[5:3]));
            chk(vec_tag(i), mask_level, int'(v[2:0]));
        end

        finish_run();
    end

endmodule